// File: doc/BRIEF.md
# UART Line Status and Interrupt Generator

This block produces the line status byte and the interrupt outputs for one UART channel with 16-entry transmit and receive FIFOs. It does not hold the FIFO storage. It observes the FIFO fill counts, the transmit shift register busy flag and the error flags that travel with each received character. From the control fields it also takes the FIFO enable, a 2-bit trigger select and a 4-bit interrupt enable nibble.

The receive interrupt follows a programmable fill threshold. It stays asserted until the fill count drops below that threshold. The data-ready flag is separate: it is set whenever the receive FIFO holds anything. Line status bit 7 summarises whether any character still in the receive FIFO carries an error. An internal count of errored entries drives it, and that count follows push and pop strobes. With all interrupt enables cleared the block runs in polled mode: no interrupt is raised, and the status bits can still be read. A one-bit read select returns either the status byte or the interrupt code, for test access.

All outputs are registered. Each output reflects the inputs sampled at the previous rising clock edge.

Top module: `uart_line_status`

## Requirements
- R1: Line status bit 0 (data ready) is 1 exactly when the receive fill count is non-zero.
- R2: Line status bits 4:1 equal the head-character error flags `rx_head_err[3:0]` while the receive FIFO is non-empty, and are 0 when it is empty.
- R3: Line status bit 5 is 1 when the transmit fill count is 0. Bit 6 is 1 only when the transmit fill count is 0 and `tx_shift_busy` is 0.
- R4: Line status bit 7 is 1 while the count of errored entries is non-zero. That count works as follows:
  - It rises by one on `rx_push` with any `rx_push_err` bit set.
  - It falls by one on `rx_pop` with any `rx_head_err` bit set.
  - It is unchanged when both strobes occur with errors in the same cycle.
  - It saturates at 16 and at 0.
  - It is zeroed by `rx_flush`.
- R5: The receive trigger level is 1, 4, 8 or 14 bytes for `trig_sel` 0, 1, 2 or 3 while `fifo_en` is 1. It is 1 byte while `fifo_en` is 0.
- R6: `irq_rx` is 1 exactly when `ier[0]` is 1 and the receive fill count is at or above the trigger level. It therefore clears only once the fill drops below that level.
- R7: `irq_tx` is 1 exactly when `ier[1]` is 1 and the transmit fill count is 0.
- R8: `isr` is 4'b0100 when a receive interrupt is pending, otherwise 4'b0010 when a transmit interrupt is pending, otherwise 4'b0001. Receive has priority.
- R9: With `ier` equal to 0 (polled mode), neither interrupt asserts, `isr` reads 4'b0001, and the line status bits behave as in R1 to R4.
- R10: `rd_data` returns the line status byte when `rd_sel` is 0 and {4'b0000, isr} when `rd_sel` is 1. Repeated reads of the interrupt code do not clear a pending receive condition.
- R11: On reset, the line status byte is 0, both interrupts are 0, `isr` is 4'b0001 and the errored-entry count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| trig_sel | input | 2 | Receive trigger level select |
| ier | input | 4 | Interrupt enable nibble (bit 0 receive, bit 1 transmit) |
| rx_count | input | 5 | Receive FIFO fill count |
| tx_count | input | 5 | Transmit FIFO fill count |
| tx_shift_busy | input | 1 | Transmit shift register holds a character |
| rx_push | input | 1 | Character written into receive FIFO this cycle |
| rx_push_err | input | 4 | Error flags of the character being pushed |
| rx_pop | input | 1 | Head character removed from receive FIFO this cycle |
| rx_head_err | input | 4 | Error flags of the head character |
| rx_flush | input | 1 | Receive FIFO cleared this cycle |
| rd_sel | input | 1 | Read select: 0 status byte, 1 interrupt code |
| lsr | output | 8 | Line status byte |
| irq_rx | output | 1 | Receive data available interrupt |
| irq_tx | output | 1 | Transmit empty interrupt |
| isr | output | 4 | Interrupt status code |
| rd_data | output | 8 | Test read data |

## Verification
The hardest state to reach from the ports is bit 7 of the line status byte. It depends on a running count of errored entries, not on any present input, so it can only be moved by particular sequences of push, pop and flush strobes. The bench builds these sequences on purpose:
- errored pushes mixed with clean ones,
- a pop and an errored push in the same cycle, which leaves the count unchanged,
- a drain down to zero,
- a flush that zeroes a count above one.

The trigger thresholds are exercised one byte below and exactly at each level.

// File: rtl/uart_line_status_pkg.sv
package uart_line_status_pkg;

    localparam int FIFO_DEPTH = 16;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int ERR_W      = 4;

    typedef struct packed {
        logic             err_in_fifo;
        logic             tx_all_empty;
        logic             tx_fifo_empty;
        logic [ERR_W-1:0] rx_err;
        logic             data_ready;
    } lsr_t;

    typedef enum logic [3:0] {
        ISR_NONE = 4'b0001,
        ISR_TX   = 4'b0010,
        ISR_RX   = 4'b0100
    } isr_e;

    function automatic logic [CNT_W-1:0] trig_level(input logic fen, input logic [1:0] sel);
        if (!fen) return CNT_W'(1);
        case (sel)
            2'd0:    return CNT_W'(1);
            2'd1:    return CNT_W'(4);
            2'd2:    return CNT_W'(8);
            default: return CNT_W'(14);
        endcase
    endfunction

endpackage

// File: rtl/uls_err_tracker.sv
module uls_err_tracker
    import uart_line_status_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int CW    = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [ERR_W-1:0] push_err,
    input  logic             pop,
    input  logic [ERR_W-1:0] head_err,
    input  logic             flush,
    output logic             any_next
);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          inc, dec;

    assign inc = push && (push_err != '0);
    assign dec = pop  && (head_err != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (flush)
            cnt_d = '0;
        else if (inc && !dec && cnt_q != CW'(DEPTH))
            cnt_d = cnt_q + CW'(1);
        else if (dec && !inc && cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign any_next = (cnt_d != '0);

    assert_err_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    assert_flush_zero_R4: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt_q == '0));

endmodule

// File: rtl/uls_int_ctrl.sv
module uls_int_ctrl
    import uart_line_status_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          fifo_en,
    input  logic [1:0]    trig_sel,
    input  logic [3:0]    ier,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    output logic          rx_pend,
    output logic          tx_pend,
    output isr_e          code
);

    logic [CW-1:0] level;

    assign level   = trig_level(fifo_en, trig_sel);
    assign rx_pend = ier[0] && (rx_count >= level);
    assign tx_pend = ier[1] && (tx_count == '0);

    always_comb begin
        if (rx_pend)      code = ISR_RX;
        else if (tx_pend) code = ISR_TX;
        else              code = ISR_NONE;
    end

    always_comb begin
        assert_code_onehot_R8: assert ($onehot(code));
    end

endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
    import uart_line_status_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [3:0]       ier,
    input  logic [CW-1:0]    rx_count,
    input  logic [CW-1:0]    tx_count,
    input  logic             tx_shift_busy,
    input  logic             rx_push,
    input  logic [ERR_W-1:0] rx_push_err,
    input  logic             rx_pop,
    input  logic [ERR_W-1:0] rx_head_err,
    input  logic             rx_flush,
    input  logic             rd_sel,
    output logic [7:0]       lsr,
    output logic             irq_rx,
    output logic             irq_tx,
    output logic [3:0]       isr,
    output logic [7:0]       rd_data
);

    logic err_any_d;
    logic rx_pend, tx_pend;
    isr_e code_d;
    lsr_t lsr_d, lsr_q;
    isr_e isr_q;

    uls_err_tracker #(.DEPTH(DEPTH), .CW(CW)) u_err (
        .clk      (clk),
        .rst      (rst),
        .push     (rx_push),
        .push_err (rx_push_err),
        .pop      (rx_pop),
        .head_err (rx_head_err),
        .flush    (rx_flush),
        .any_next (err_any_d)
    );

    uls_int_ctrl #(.CW(CW)) u_int (
        .fifo_en  (fifo_en),
        .trig_sel (trig_sel),
        .ier      (ier),
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_pend  (rx_pend),
        .tx_pend  (tx_pend),
        .code     (code_d)
    );

    always_comb begin
        lsr_d.data_ready    = (rx_count != '0);
        lsr_d.rx_err        = lsr_d.data_ready ? rx_head_err : '0;
        lsr_d.tx_fifo_empty = (tx_count == '0);
        lsr_d.tx_all_empty  = (tx_count == '0) && !tx_shift_busy;
        lsr_d.err_in_fifo   = err_any_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lsr_q   <= '0;
            isr_q   <= ISR_NONE;
            irq_rx  <= 1'b0;
            irq_tx  <= 1'b0;
            rd_data <= '0;
        end else begin
            lsr_q   <= lsr_d;
            isr_q   <= code_d;
            irq_rx  <= rx_pend;
            irq_tx  <= tx_pend;
            rd_data <= rd_sel ? {4'b0000, code_d} : lsr_d;
        end
    end

    assign lsr = lsr_q;
    assign isr = isr_q;

    assert_temt_implies_thre_R3: assert property (@(posedge clk) disable iff (rst)
        lsr[6] |-> lsr[5]);

    assert_txirq_needs_empty_R7: assert property (@(posedge clk) disable iff (rst)
        irq_tx |-> lsr[5]);

    assert_rxirq_needs_data_R6: assert property (@(posedge clk) disable iff (rst)
        irq_rx |-> lsr[0]);

    assert_polled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(ier) == 4'b0000) |-> (!irq_rx && !irq_tx));

    assert_rx_priority_R8: assert property (@(posedge clk) disable iff (rst)
        irq_rx |-> (isr == 4'b0100));

endmodule

// File: tb/uart_line_status_tb.sv
module uart_line_status_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       fifo_en;
    logic [1:0] trig_sel;
    logic [3:0] ier;
    logic [4:0] rx_count, tx_count;
    logic       tx_shift_busy;
    logic       rx_push, rx_pop, rx_flush, rd_sel;
    logic [3:0] rx_push_err, rx_head_err;
    logic [7:0] lsr, rd_data;
    logic       irq_rx, irq_tx;
    logic [3:0] isr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    uart_line_status u_dut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel), .ier(ier),
        .rx_count(rx_count), .tx_count(tx_count), .tx_shift_busy(tx_shift_busy),
        .rx_push(rx_push), .rx_push_err(rx_push_err), .rx_pop(rx_pop),
        .rx_head_err(rx_head_err), .rx_flush(rx_flush), .rd_sel(rd_sel),
        .lsr(lsr), .irq_rx(irq_rx), .irq_tx(irq_tx), .isr(isr), .rd_data(rd_data)
    );

    // {fen, trig, ier, rxc, txc, busy, herr, exp_lsr, exp_irx, exp_itx, exp_isr}
    localparam int NV = 13;
    localparam logic [35:0] VEC [NV] = '{
        {1'b1,2'd0,4'h1,5'd0, 5'd0,1'b0,4'h0,8'h60,1'b0,1'b0,4'h1}, // R1 R3 empty
        {1'b1,2'd0,4'h3,5'd1, 5'd0,1'b0,4'h0,8'h61,1'b1,1'b1,4'h4}, // R6 R8 priority
        {1'b1,2'd1,4'h3,5'd3, 5'd0,1'b1,4'h0,8'h21,1'b0,1'b1,4'h2}, // R5 below 4
        {1'b1,2'd1,4'h3,5'd4, 5'd0,1'b1,4'h0,8'h21,1'b1,1'b1,4'h4}, // R5 at 4
        {1'b1,2'd2,4'h3,5'd7, 5'd5,1'b0,4'h0,8'h01,1'b0,1'b0,4'h1}, // R5 below 8
        {1'b1,2'd2,4'h3,5'd8, 5'd5,1'b0,4'h0,8'h01,1'b1,1'b0,4'h4}, // R5 at 8
        {1'b1,2'd3,4'h3,5'd13,5'd2,1'b0,4'h0,8'h01,1'b0,1'b0,4'h1}, // R5 below 14
        {1'b1,2'd3,4'h3,5'd14,5'd2,1'b0,4'h0,8'h01,1'b1,1'b0,4'h4}, // R5 at 14
        {1'b1,2'd3,4'h3,5'd16,5'd0,1'b0,4'hA,8'h75,1'b1,1'b1,4'h4}, // R2 full, errors
        {1'b1,2'd0,4'h0,5'd5, 5'd0,1'b0,4'h1,8'h63,1'b0,1'b0,4'h1}, // R9 polled
        {1'b0,2'd3,4'h1,5'd1, 5'd3,1'b0,4'h0,8'h01,1'b1,1'b0,4'h4}, // R5 non-FIFO level 1
        {1'b1,2'd0,4'h3,5'd0, 5'd0,1'b1,4'hF,8'h20,1'b0,1'b1,4'h2}, // R2 masked, R7
        {1'b1,2'd3,4'h2,5'd16,5'd0,1'b0,4'h0,8'h61,1'b0,1'b1,4'h2}  // R7 only tx enabled
    };

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe(input logic push, input logic [3:0] perr,
                          input logic pop, input logic flush);
        rx_push = push; rx_push_err = perr; rx_pop = pop; rx_flush = flush;
        cyc();
        rx_push = 0; rx_push_err = 0; rx_pop = 0; rx_flush = 0;
    endtask

    initial begin
        #(5 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; fifo_en = 1; trig_sel = 0; ier = 4'h3; rx_count = 5'd3; tx_count = 0;
        tx_shift_busy = 0; rx_push = 0; rx_push_err = 0; rx_pop = 0; rx_head_err = 0;
        rx_flush = 0; rd_sel = 0;
        @(negedge clk);
        cyc();
        // R11 reset state
        chk8("R11 lsr", lsr, 8'h00);
        chk8("R11 isr", {4'h0, isr}, 8'h01);
        chk8("R11 irq", {6'b0, irq_rx, irq_tx}, 8'h00);
        rst = 0;

        for (int i = 0; i < NV; i++) begin
            logic [35:0] v;
            v = VEC[i];
            fifo_en = v[35]; trig_sel = v[34:33]; ier = v[32:29];
            rx_count = v[28:24]; tx_count = v[23:19]; tx_shift_busy = v[18];
            rx_head_err = v[17:14]; rd_sel = i[0];
            cyc();
            n_checks++;
            if (lsr !== v[13:6] || irq_rx !== v[5] || irq_tx !== v[4] || isr !== v[3:0] ||
                rd_data !== (i[0] ? {4'h0, v[3:0]} : v[13:6])) begin
                n_fail++;
                $display("FAIL table %0d R1 R2 R3 R5 R6 R7 R8 R9 R10: actual lsr=%h rx=%b tx=%b isr=%h rd=%h expected lsr=%h rx=%b tx=%b isr=%h",
                         i, lsr, irq_rx, irq_tx, isr, rd_data, v[13:6], v[5], v[4], v[3:0]);
            end
        end

        // R4 errored-entry tracking
        fifo_en = 1; ier = 0; rx_count = 5'd2; tx_count = 5'd1; tx_shift_busy = 1;
        rx_head_err = 0; rd_sel = 0;
        cyc();
        chk8("R4 clean start", lsr, 8'h01);
        strobe(1, 4'h2, 0, 0);
        chk8("R4 errored push sets bit7", lsr, 8'h81);
        strobe(1, 4'h0, 0, 0);
        chk8("R4 clean push keeps bit7", lsr, 8'h81);
        rx_head_err = 4'h2;
        strobe(1, 4'h4, 1, 0);
        chk8("R4 push and pop with errors hold", lsr, 8'h85);
        strobe(0, 4'h0, 1, 0);
        chk8("R4 last errored pop clears bit7", lsr, 8'h05);
        rx_head_err = 0;
        strobe(1, 4'h8, 0, 0);
        strobe(1, 4'h1, 0, 0);
        chk8("R4 two errored entries", lsr, 8'h81);
        rx_head_err = 4'h1;
        strobe(0, 4'h0, 1, 0);
        chk8("R4 one errored entry left", lsr, 8'h83);
        rx_head_err = 0;
        strobe(1, 4'h8, 0, 0);
        strobe(0, 4'h0, 0, 1);
        chk8("R4 flush clears bit7", lsr, 8'h01);
        rx_head_err = 4'h1;
        strobe(0, 4'h0, 1, 0);
        chk8("R4 pop at zero stays zero", lsr, 8'h03);
        rx_head_err = 0;

        // R10 repeated interrupt-code reads leave receive condition pending
        ier = 4'h1; trig_sel = 2'd1; rx_count = 5'd5; rd_sel = 1;
        for (int k = 0; k < 4; k++) begin
            cyc();
            chk8("R10 isr read does not clear", rd_data, 8'h04);
        end
        // R6 hysteresis: fill at 4 keeps interrupt, 3 clears it
        rx_count = 5'd4;
        cyc();
        chk8("R6 at level still pending", {7'b0, irq_rx}, 8'h01);
        rx_count = 5'd3;
        cyc();
        chk8("R6 below level clears", {7'b0, irq_rx}, 8'h00);
        chk8("R8 none code", {4'h0, isr}, 8'h01);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule